// File: doc/BRIEF.md
# Staged Transformation Parameter Bank with Window Flag

This block keeps a small set of transformation parameters in two layers. Software or a sequencer writes single values by address into a preload layer. A load strobe then moves the whole preload layer into the working layer on one clock edge, so downstream logic never sees a half-updated parameter set. The working layer is presented on a flat output bus.

Two working entries act as the lower and upper bounds of a one-dimensional window. A registered comparator checks an incoming signed source coordinate against that window and raises an in-window flag. An instance per axis can be combined with an AND gate, and a LOW result marks a source point outside the rectangle spanned by the two axes' limits. Coordinates that are negative or that exceed the 12-bit range always count as outside, whatever the limits are.

Top module: `xform_param_bank`

## Requirements
- R1: The write enable, load strobe, address and data inputs are registered before use. A write or load presented before clock edge E takes effect on edge E+1 and is visible on `work_o` after that edge.
- R2: With `wr_n_i` LOW, the value on `wdata_i` is written into the preload entry chosen by `waddr_i`. No other preload entry changes.
- R3: With `load_i` HIGH, all preload entries are copied into their working entries on the same edge. Entry k occupies bits [16k+15:16k] of `work_o`.
- R4: With `load_i` LOW, every working entry holds its value, even while preload entries are rewritten.
- R5: A write and a load sampled in the same cycle make the load transfer the preload contents from before the write. The new value reaches the working layer only on a later load.
- R6: `in_win_o` is registered. After edge E it is HIGH exactly when the `coord_i` sampled at E satisfies lo ≤ coord ≤ hi and lies in 0..4095. Here lo is bits [11:0] of working entry 0 and hi is bits [11:0] of working entry 1, both unsigned.
- R7: A `coord_i` that is negative (14-bit two's complement) or at least 4096 yields `in_win_o` LOW, even when the limits span the full range.
- R8: Reset clears every preload and working entry to zero. With lo = hi = 0, a coordinate of 0 gives `in_win_o` HIGH on the first edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_n_i | input | 1 | Preload write enable, active low |
| waddr_i | input | 3 | Preload entry select |
| wdata_i | input | 16 | Value to write |
| load_i | input | 1 | Transfer of all preload entries to the working layer |
| coord_i | input | 14 | Signed source coordinate |
| work_o | output | 128 | Working entries, flattened; entry 0 in the low bits |
| in_win_o | output | 1 | Registered in-window flag |

## Verification
Four properties run on every cycle. A working entry stays stable whenever no load was sampled. An addressed write lands in its preload entry and leaves the other entries alone. A HIGH flag always traces back to an in-range coordinate lying between the limits. Behaviour that depends on ordering across cycles can only be shown by the bench scenarios. This covers the one-cycle input registration, a write and load landing together, and the exact flag value at the limit boundaries, at -1 and at 4096. The bench checks each of these against a cycle model built from the requirements, under both directed and random traffic.

// File: rtl/xpb_pkg.sv
package xpb_pkg;

   // registered control bundle handed from the input stage to the bank
   typedef struct packed {
      logic wr_n;
      logic load;
   } xpb_ctrl_t;

   localparam xpb_ctrl_t XPB_CTRL_IDLE = '{wr_n: 1'b1, load: 1'b0};

endpackage

// File: rtl/xpb_input_stage.sv
module xpb_input_stage
   import xpb_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int PARAM_W = 16
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_n_i,
   input  logic               load_i,
   input  logic [ADDR_W-1:0]  waddr_i,
   input  logic [PARAM_W-1:0] wdata_i,
   output xpb_ctrl_t          ctrl_o,
   output logic [ADDR_W-1:0]  addr_o,
   output logic [PARAM_W-1:0] data_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_o <= XPB_CTRL_IDLE;
         addr_o <= '0;
         data_o <= '0;
      end else begin
         ctrl_o.wr_n <= wr_n_i;
         ctrl_o.load <= load_i;
         addr_o      <= waddr_i;
         data_o      <= wdata_i;
      end
   end

endmodule

// File: rtl/xpb_reg_bank.sv
module xpb_reg_bank
   import xpb_pkg::*;
#(
   parameter int N_REGS  = 8,
   parameter int ADDR_W  = 3,
   parameter int PARAM_W = 16
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  xpb_ctrl_t                 ctrl_i,
   input  logic [ADDR_W-1:0]         addr_i,
   input  logic [PARAM_W-1:0]        data_i,
   output logic [N_REGS*PARAM_W-1:0] work_o
);

   logic [PARAM_W-1:0] pre_q  [N_REGS];
   logic [PARAM_W-1:0] work_q [N_REGS];

   for (genvar gi = 0; gi < N_REGS; gi++) begin : g_entry
      logic sel;
      assign sel = !ctrl_i.wr_n && (addr_i == ADDR_W'(gi));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)  pre_q[gi] <= '0;
         else if (sel) pre_q[gi] <= data_i;
      end

      // the load reads pre_q before this edge's write lands (R5)
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)          work_q[gi] <= '0;
         else if (ctrl_i.load) work_q[gi] <= pre_q[gi];
      end

      assign work_o[gi*PARAM_W +: PARAM_W] = work_q[gi];

      assert_work_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !ctrl_i.load |=> $stable(work_o[gi*PARAM_W +: PARAM_W]))
         else $error("working entry changed without load");

      assert_write_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!ctrl_i.wr_n && addr_i == ADDR_W'(gi)) |=> pre_q[gi] == $past(data_i))
         else $error("addressed preload entry not written");

      assert_other_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ctrl_i.wr_n || addr_i != ADDR_W'(gi)) |=> $stable(pre_q[gi]))
         else $error("unaddressed preload entry changed");
   end

endmodule

// File: rtl/xpb_window_cmp.sv
module xpb_window_cmp #(
   parameter int X_W     = 14,
   parameter int COORD_W = 12
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [X_W-1:0]     coord_i,
   input  logic [COORD_W-1:0] lo_i,
   input  logic [COORD_W-1:0] hi_i,
   output logic               flag_o
);

   localparam int EXT_W = X_W - COORD_W;

   logic               in_range;
   logic [COORD_W-1:0] c_low;
   logic               hit;

   // sign bit and overflow bits must all be clear
   assign in_range = (coord_i[X_W-1 -: EXT_W] == '0);
   assign c_low    = coord_i[COORD_W-1:0];
   assign hit      = in_range && (c_low >= lo_i) && (c_low <= hi_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o <= 1'b0;
      else         flag_o <= hit;
   end

   assert_outside_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o |-> ($past(coord_i[X_W-1 -: EXT_W]) == '0))
      else $error("flag high for negative or oversize coordinate");

   assert_limits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flag_o |-> ($past(coord_i[COORD_W-1:0]) >= $past(lo_i)
               && $past(coord_i[COORD_W-1:0]) <= $past(hi_i)))
      else $error("flag high outside window limits");

endmodule

// File: rtl/xform_param_bank.sv
module xform_param_bank
   import xpb_pkg::*;
#(
   parameter int N_REGS  = 8,
   parameter int PARAM_W = 16,
   parameter int COORD_W = 12,
   parameter int X_W     = 14,
   parameter int LO_IDX  = 0,
   parameter int HI_IDX  = 1,
   localparam int ADDR_W = $clog2(N_REGS)
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      wr_n_i,
   input  logic [ADDR_W-1:0]         waddr_i,
   input  logic [PARAM_W-1:0]        wdata_i,
   input  logic                      load_i,
   input  logic [X_W-1:0]            coord_i,
   output logic [N_REGS*PARAM_W-1:0] work_o,
   output logic                      in_win_o
);

   if (N_REGS < 2)                              $error("N_REGS must be at least 2");
   if (PARAM_W < COORD_W)                       $error("PARAM_W narrower than COORD_W");
   if (X_W <= COORD_W)                          $error("X_W needs sign/overflow bits");
   if (LO_IDX >= N_REGS || HI_IDX >= N_REGS)    $error("limit index out of range");
   if (LO_IDX == HI_IDX)                        $error("limit indices must differ");

   xpb_ctrl_t           ctrl_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [PARAM_W-1:0]  data_q;

   xpb_input_stage #(.ADDR_W(ADDR_W), .PARAM_W(PARAM_W)) u_in (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_n_i  (wr_n_i),
      .load_i  (load_i),
      .waddr_i (waddr_i),
      .wdata_i (wdata_i),
      .ctrl_o  (ctrl_q),
      .addr_o  (addr_q),
      .data_o  (data_q)
   );

   xpb_reg_bank #(.N_REGS(N_REGS), .ADDR_W(ADDR_W), .PARAM_W(PARAM_W)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ctrl_i (ctrl_q),
      .addr_i (addr_q),
      .data_i (data_q),
      .work_o (work_o)
   );

   xpb_window_cmp #(.X_W(X_W), .COORD_W(COORD_W)) u_cmp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .coord_i (coord_i),
      .lo_i    (work_o[LO_IDX*PARAM_W +: COORD_W]),
      .hi_i    (work_o[HI_IDX*PARAM_W +: COORD_W]),
      .flag_o  (in_win_o)
   );

   assert_reset_clear_R8: assert property (@(posedge clk_i)
      $rose(rst_ni) |-> (work_o == '0))
      else $error("working layer not clear after reset");

endmodule

// File: tb/xform_param_bank_bench.sv
module xform_param_bank_bench;

   localparam int NR = 8;
   localparam int PW = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_n = 1'b1;
   logic [2:0]      waddr = '0;
   logic [15:0]     wdata = '0;
   logic            load = 1'b0;
   logic [13:0]     coord = '0;
   logic [NR*PW-1:0] work;
   logic            in_win;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // cycle model state
   logic        m_wr_n = 1'b1, m_load = 1'b0;
   logic [2:0]  m_addr = '0;
   logic [15:0] m_data = '0;
   logic [15:0] m_pre  [NR];
   logic [15:0] m_work [NR];
   logic        m_flag = 1'b0;

   always #10 clk = ~clk;

   xform_param_bank u_xform_param_bank (
      .clk_i(clk), .rst_ni(rst_n), .wr_n_i(wr_n), .waddr_i(waddr),
      .wdata_i(wdata), .load_i(load), .coord_i(coord),
      .work_o(work), .in_win_o(in_win)
   );

   function automatic logic exp_flag(logic [13:0] x, logic [15:0] lo, logic [15:0] hi);
      int sx = $signed(x);
      return (sx >= 0) && (sx < 4096) && (x[11:0] >= lo[11:0]) && (x[11:0] <= hi[11:0]);
   endfunction

   task automatic check(string tag);
      logic [NR*PW-1:0] exp_w;
      for (int k = 0; k < NR; k++) exp_w[k*PW +: PW] = m_work[k];
      checks++;
      if (work !== exp_w) begin
         errors++;
         $display("FAIL %s work_o actual=%h expected=%h", tag, work, exp_w);
      end
      checks++;
      if (in_win !== m_flag) begin
         errors++;
         $display("FAIL %s in_win_o actual=%b expected=%b", tag, in_win, m_flag);
      end
   endtask

   // called at a negedge; drives, steps model at the edge, checks at next negedge
   task automatic cyc(logic wn, logic ld, logic [2:0] a, logic [15:0] d,
                      logic [13:0] x, string tag);
      wr_n = wn; load = ld; waddr = a; wdata = d; coord = x;
      @(posedge clk);
      m_flag = exp_flag(x, m_work[0], m_work[1]);
      if (m_load) for (int k = 0; k < NR; k++) m_work[k] = m_pre[k];
      if (!m_wr_n) m_pre[m_addr] = m_data;
      m_wr_n = wn; m_load = ld; m_addr = a; m_data = d;
      @(negedge clk);
      check(tag);
   endtask

   task automatic idle(logic [13:0] x, string tag);
      cyc(1'b1, 1'b0, 3'd0, 16'h0, x, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed1234));
      for (int k = 0; k < NR; k++) begin m_pre[k] = '0; m_work[k] = '0; end
      repeat (3) @(negedge clk);
      // R8: cleared state during reset
      check("R8");
      rst_n = 1'b1;
      // R8: coord 0 inside a 0..0 window right after reset
      idle(14'd0, "R8");
      idle(14'd1, "R8");

      // R1/R2/R4: write lands in preload only, working stays
      cyc(1'b0, 1'b0, 3'd1, 16'h0FFF, 14'd5, "R2");
      cyc(1'b0, 1'b0, 3'd0, 16'h0010, 14'd5, "R4");
      idle(14'd5, "R4");
      idle(14'd5, "R4");
      // R1/R3: load sampled here, visible after next edge
      cyc(1'b1, 1'b1, 3'd0, 16'h0, 14'd5, "R1");
      idle(14'h0010, "R3");
      // R6 boundaries with lo=0x10, hi=0xFFF
      idle(14'h000F, "R6");
      idle(14'h0010, "R6");
      idle(14'h0FFF, "R6");
      idle(14'h0800, "R6");
      // widen to full range, then R7 outside values
      cyc(1'b0, 1'b0, 3'd0, 16'h0000, 14'd0, "R2");
      cyc(1'b1, 1'b1, 3'd0, 16'h0, 14'd0, "R3");
      idle(14'h0FFF, "R6");
      idle(14'h1000, "R7");
      idle(14'h3FFF, "R7");
      idle(14'h2000, "R7");
      idle(14'h1FFF, "R7");
      idle(14'h0000, "R6");

      // R5: write and load together move the old value
      cyc(1'b0, 1'b1, 3'd1, 16'h0100, 14'd0, "R5");
      idle(14'h0200, "R5");
      idle(14'h0200, "R5");
      cyc(1'b1, 1'b1, 3'd0, 16'h0, 14'h0200, "R5");
      idle(14'h0200, "R5");
      idle(14'h0100, "R6");

      // R6 narrow window lo=hi
      cyc(1'b0, 1'b0, 3'd0, 16'h0100, 14'h0, "R2");
      cyc(1'b1, 1'b1, 3'd0, 16'h0, 14'h0, "R3");
      idle(14'h0100, "R6");
      idle(14'h00FF, "R6");
      idle(14'h0101, "R6");

      // random traffic, mixed intent
      for (int n = 0; n < 3000; n++) begin
         logic        wn = ($urandom % 3) == 0 ? 1'b0 : 1'b1;
         logic        ld = ($urandom % 5) == 0;
         logic [2:0]  a  = 3'($urandom);
         logic [15:0] d  = ($urandom % 2) ? 16'($urandom % 4096) : 16'($urandom);
         logic [13:0] x;
         case ($urandom % 4)
            0: x = 14'($urandom);
            1: x = 14'(m_work[0][11:0]);
            2: x = 14'(m_work[1][11:0]);
            default: x = 14'($urandom % 4096);
         endcase
         cyc(wn, ld, a, d, x, ld ? "R3" : (!wn ? "R4" : "R6"));
      end

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule